// File: doc/BRIEF.md
# Strand Privileged Control Register File

This block holds the privileged and hyper-privileged control state of one processor strand behind a single request port. Each request carries an address, a read/write flag and write data. Reads return their data one clock later. Writes take effect at the clock edge that accepts them. Some registers do more on a write than store the data: the processor-state register keeps only its defined bits, the trap base address is aligned, and the trap level and window pointer saturate. The virtual tick is not a counter of its own. It is stored as an offset from a free-running cycle count supplied from outside, plus one separate flag bit.

Five save stacks (saved PC, saved next PC, saved state, trap type and hyper saved state) hold one 64-bit entry per trap level. They are addressed through the current trap level, using entry `level - 1`. The block also holds eight scratchpad words and eight interrupt-queue pointers. It continuously exports a packed context word for the address translation unit, and it drives a trap-level-zero interrupt request.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset the strand status register (0x06) reads 0x50000. All other registers, the scratchpads, the queue pointers and every save stack entry read zero. `rsp_err` and `tlz_irq` are low.
- R2: A write to the processor-state register (0x00) stores only data bits 12, 9:6 and 4:1 (mask 0x13DE). All other bits read back as zero.
- R3: A write to the trap base register (0x01) stores the data with bits 14:0 forced to zero.
- R4: The save stacks are at 0x10 (saved PC), 0x11 (saved next PC), 0x12 (saved state), 0x13 (trap type) and 0x14 (hyper saved state). Each access uses the entry at trap level minus one. Each level keeps its own value for every stack.
- R5: While the trap level is 0, a read or write of a save stack address is rejected: it returns zero, pulses `rsp_err` and changes no entry.
- R6: A trap level write (0x02) stores min(data, MAX_TL). A global level write (0x03) stores data bits 2:0.
- R7: A window pointer write (0x04) with data at or above N_WIN stores N_WIN-1. Smaller values are stored unchanged.
- R8: `tlz_irq` is high exactly when hyper-state (0x05) bit 0 is set, hyper-state bit 2 is clear and the trap level is 0.
- R9: `ctx_word` and a read of address 0x0C give the following fields: bit 0 = hyper-state bit 2, bit 1 = hyper-state bit 5, bits 3:2 = processor-state bits 3:2, bits 5:4 = load/store control (0x0B) bits 3:2, bits 15:8 = partition ID (0x0A, 8 bits), bits 18:16 = trap level, bits 47:32 = primary context (0x08, 16 bits), bits 63:48 = secondary context (0x09, 16 bits). All other bits are zero.
- R10: A tick write (0x07) stores offset = data[62:0] - cycle_cnt (modulo 2^63) and stores data bit 63 as a flag. A tick read returns the flag in bit 63, bits 62:2 of (cycle_cnt + offset), and zeros in bits 1:0.
- R11: Scratchpads 0x18..0x1F and queue pointers 0x20..0x27 store and return full 64-bit values independently. The queue pointers are ordered head then tail, for CPU, device, resumable error and non-resumable error queues.
- R12: An access to an unmapped address, or a write to the read-only context word 0x0C, returns zero, raises `rsp_err` in the next cycle only, and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_cnt | input | 63 | Free-running cycle count that the tick is based on |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, one cycle after the request |
| rsp_err | output | 1 | One-cycle pulse for a rejected request |
| ctx_word | output | 64 | Packed context word for the translation unit |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
Several properties are checked on every cycle, whatever the stimulus:
- the masking of processor-state and trap base read data;
- the window pointer range;
- the zero low bits of the tick;
- the trap level bound;
- the agreement between the interrupt request and the exported trap level and hyper-privilege bit;
- the rule that a context-word read returns the exported word;
- the rule that rejected requests return zero data.

Only the directed scenarios can show that values actually land where they should. That covers per-level stack retention, the tick offset arithmetic across a counter wrap, saturation results, and the fact that rejected writes leave state untouched.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 64;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t A_PSTATE = 6'h00;
  localparam addr_t A_TBA    = 6'h01;
  localparam addr_t A_TL     = 6'h02;
  localparam addr_t A_GL     = 6'h03;
  localparam addr_t A_CWP    = 6'h04;
  localparam addr_t A_HPST   = 6'h05;
  localparam addr_t A_STRAND = 6'h06;
  localparam addr_t A_TICK   = 6'h07;
  localparam addr_t A_PCTX   = 6'h08;
  localparam addr_t A_SCTX   = 6'h09;
  localparam addr_t A_PART   = 6'h0A;
  localparam addr_t A_LSU    = 6'h0B;
  localparam addr_t A_CTXW   = 6'h0C;
  localparam addr_t A_STK    = 6'h10;
  localparam int    N_STK    = 5;
  localparam int    N_SCR    = 8;
  localparam int    N_QPTR   = 8;
  localparam logic [2:0] SCR_PAGE = 3'b011;
  localparam logic [2:0] QP_PAGE  = 3'b100;

  localparam word_t PSTATE_KEEP = 64'h0000_0000_0000_13DE;
  localparam word_t TBA_CLEAR   = 64'h0000_0000_0000_7FFF;
  localparam word_t STRAND_RST  = 64'h0000_0000_0005_0000;

  function automatic word_t pstate_keep_f(word_t v);
    return v & PSTATE_KEEP;
  endfunction

  function automatic word_t tba_align_f(word_t v);
    return v & ~TBA_CLEAR;
  endfunction

  function automatic word_t sat_f(word_t v, word_t lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [62:0] tick_offset_f(logic [62:0] v, logic [62:0] cnt);
    return v - cnt;
  endfunction

  function automatic word_t tick_view_f(logic flag, logic [62:0] off, logic [62:0] cnt);
    logic [62:0] sum;
    sum = cnt + off;
    return {flag, sum & ~63'h3};
  endfunction

  function automatic word_t pack_ctx_f(logic hp2, logic hp5, logic [1:0] ps32,
                                       logic [1:0] lsu32, logic [7:0] part,
                                       logic [2:0] tl, logic [15:0] pctx,
                                       logic [15:0] sctx);
    return {sctx, pctx, 13'b0, tl, part, 2'b00, lsu32, ps32, hp5, hp2};
  endfunction

  function automatic logic tlz_req_f(logic tlz, logic hpriv, logic [2:0] tl);
    return tlz && !hpriv && (tl == 3'd0);
  endfunction
endpackage

// File: rtl/ctlreg_array.sv
module ctlreg_array #(
  parameter int COUNT = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata
);
  logic [63:0] mem [COUNT];
  logic        in_range;

  assign in_range = int'(idx) < COUNT;
  assign rdata    = in_range ? mem[idx] : 64'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < COUNT; i++) mem[i] <= 64'd0;
    end else if (wr_en && in_range) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/ctlreg_tick.sv
module ctlreg_tick
  import ctlreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  word_t       wdata,
  input  logic [62:0] cycle_cnt,
  output word_t       rd_val
);
  logic [62:0] off_q;
  logic        flag_q;

  assign rd_val = tick_view_f(flag_q, off_q, cycle_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= 63'd0;
      flag_q <= 1'b0;
    end else if (wr_en) begin
      off_q  <= tick_offset_f(wdata[62:0], cycle_cnt);
      flag_q <= wdata[63];
    end
  end
endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
  import ctlreg_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int N_WIN  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [62:0] cycle_cnt,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [63:0] req_wdata,
  output logic [63:0] rsp_rdata,
  output logic        rsp_err,
  output logic [63:0] ctx_word,
  output logic        tlz_irq
);
  localparam int STK_IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
  localparam int CWP_W     = (N_WIN > 1) ? $clog2(N_WIN) : 1;

  // scalar state
  word_t             pstate_q, tba_q, hpst_q, strand_q, lsu_q;
  logic [2:0]        tl_q, gl_q;
  logic [CWP_W-1:0]  cwp_q;
  logic [15:0]       pctx_q, sctx_q;
  logic [7:0]        part_q;

  // decode events, named for the checker
  logic        is_scalar, is_stk, is_scr, is_qp, stk_ok, err_now, wr_fire;
  logic [2:0]  stk_sel, tl_m1;
  logic [STK_IDX_W-1:0] stk_idx;
  word_t       stk_rd [N_STK];
  word_t       scr_rd, qp_rd, tick_rd, rd_mux;

  assign is_scalar = req_addr <= A_CTXW;
  assign is_stk    = (req_addr >= A_STK) && (req_addr < A_STK + 6'(N_STK));
  assign is_scr    = req_addr[5:3] == SCR_PAGE;
  assign is_qp     = req_addr[5:3] == QP_PAGE;
  assign stk_sel   = 3'(req_addr - A_STK);
  assign stk_ok    = is_stk && (tl_q != 3'd0);
  assign tl_m1     = tl_q - 3'd1;
  assign stk_idx   = tl_m1[STK_IDX_W-1:0];
  assign err_now   = req_valid && (!(is_scalar || is_scr || is_qp || stk_ok) ||
                                   (req_write && req_addr == A_CTXW));
  assign wr_fire   = req_valid && req_write && !err_now;

  // save stacks, one array per kind
  for (genvar k = 0; k < N_STK; k++) begin : g_stk
    ctlreg_array #(.COUNT(MAX_TL), .IDX_W(STK_IDX_W)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_fire && stk_ok && stk_sel == 3'(k)),
      .idx   (stk_idx),
      .wdata (req_wdata),
      .rdata (stk_rd[k])
    );
  end

  ctlreg_array #(.COUNT(N_SCR), .IDX_W(3)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_fire && is_scr),
    .idx   (req_addr[2:0]),
    .wdata (req_wdata),
    .rdata (scr_rd)
  );

  ctlreg_array #(.COUNT(N_QPTR), .IDX_W(3)) u_qp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_fire && is_qp),
    .idx   (req_addr[2:0]),
    .wdata (req_wdata),
    .rdata (qp_rd)
  );

  ctlreg_tick u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire && req_addr == A_TICK),
    .wdata     (req_wdata),
    .cycle_cnt (cycle_cnt),
    .rd_val    (tick_rd)
  );

  // scalar registers with their write effects
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate_q <= '0;
      tba_q    <= '0;
      tl_q     <= '0;
      gl_q     <= '0;
      cwp_q    <= '0;
      hpst_q   <= '0;
      strand_q <= STRAND_RST;
      pctx_q   <= '0;
      sctx_q   <= '0;
      part_q   <= '0;
      lsu_q    <= '0;
    end else if (wr_fire) begin
      case (req_addr)
        A_PSTATE: pstate_q <= pstate_keep_f(req_wdata);
        A_TBA:    tba_q    <= tba_align_f(req_wdata);
        A_TL:     tl_q     <= 3'(sat_f(req_wdata, 64'(MAX_TL)));
        A_GL:     gl_q     <= req_wdata[2:0];
        A_CWP:    cwp_q    <= CWP_W'(sat_f(req_wdata, 64'(N_WIN - 1)));
        A_HPST:   hpst_q   <= req_wdata;
        A_STRAND: strand_q <= req_wdata;
        A_PCTX:   pctx_q   <= req_wdata[15:0];
        A_SCTX:   sctx_q   <= req_wdata[15:0];
        A_PART:   part_q   <= req_wdata[7:0];
        A_LSU:    lsu_q    <= req_wdata;
        default:  ;
      endcase
    end
  end

  assign ctx_word = pack_ctx_f(hpst_q[2], hpst_q[5], pstate_q[3:2], lsu_q[3:2],
                               part_q, tl_q, pctx_q, sctx_q);
  assign tlz_irq  = tlz_req_f(hpst_q[0], hpst_q[2], tl_q);

  always_comb begin
    rd_mux = '0;
    if (is_stk) begin
      rd_mux = stk_rd[stk_sel];
    end else if (is_scr) begin
      rd_mux = scr_rd;
    end else if (is_qp) begin
      rd_mux = qp_rd;
    end else begin
      case (req_addr)
        A_PSTATE: rd_mux = pstate_q;
        A_TBA:    rd_mux = tba_q;
        A_TL:     rd_mux = 64'(tl_q);
        A_GL:     rd_mux = 64'(gl_q);
        A_CWP:    rd_mux = 64'(cwp_q);
        A_HPST:   rd_mux = hpst_q;
        A_STRAND: rd_mux = strand_q;
        A_TICK:   rd_mux = tick_rd;
        A_PCTX:   rd_mux = 64'(pctx_q);
        A_SCTX:   rd_mux = 64'(sctx_q);
        A_PART:   rd_mux = 64'(part_q);
        A_LSU:    rd_mux = lsu_q;
        A_CTXW:   rd_mux = ctx_word;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= (req_valid && !req_write && !err_now) ? rd_mux : '0;
      rsp_err   <= err_now;
    end
  end
endmodule

// File: rtl/priv_ctl_regfile_chk.sv
module priv_ctl_regfile_chk
  import ctlreg_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int N_WIN  = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [5:0]  req_addr,
  input logic [63:0] rsp_rdata,
  input logic        rsp_err,
  input logic [63:0] ctx_word,
  input logic        tlz_irq
);
  logic rd_req;
  assign rd_req = req_valid && !req_write;

  assert_err_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid));
  assert_err_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 64'd0);
  assert_pstate_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_addr == 6'h00 |=> (rsp_rdata & ~64'h13DE) == 64'd0);
  assert_tba_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_addr == 6'h01 |=> rsp_rdata[14:0] == 15'd0);
  assert_tl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ctx_word[18:16]) <= MAX_TL);
  assert_cwp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_addr == 6'h04 |=> rsp_rdata < 64'(N_WIN));
  assert_tlz_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlz_irq |-> (ctx_word[18:16] == 3'd0) && !ctx_word[0]);
  assert_ctx_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_addr == 6'h0C |=> rsp_rdata == $past(ctx_word));
  assert_tick_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && req_addr == 6'h07 |=> rsp_rdata[1:0] == 2'b00);
  assert_stk_tl0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= 6'h10 && req_addr <= 6'h14 && ctx_word[18:16] == 3'd0
    |=> rsp_err);
endmodule

bind priv_ctl_regfile priv_ctl_regfile_chk #(.MAX_TL(MAX_TL), .N_WIN(N_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .ctx_word  (ctx_word),
  .tlz_irq   (tlz_irq)
);

// File: tb/priv_ctl_regfile_bench.sv
`timescale 1ns/1ps
module priv_ctl_regfile_bench;
  localparam int MAXTL = 6;
  localparam int NWIN  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [62:0] cycle_cnt = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata, ctx_word;
  logic        rsp_err, tlz_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  priv_ctl_regfile #(.MAX_TL(MAXTL), .N_WIN(NWIN)) u_priv_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .cycle_cnt(cycle_cnt),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ctx_word(ctx_word), .tlz_irq(tlz_irq));

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    err = rsp_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [63:0] d, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; err = rsp_err;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic e;
    check("R1 tlz_irq at reset", 64'(tlz_irq), 64'd0);
    check("R1 rsp_err at reset", 64'(rsp_err), 64'd0);
    rd(6'h06, d, e); check("R1 strand status", d, 64'h50000);
    rd(6'h1B, d, e); check("R1 scratch3", d, 64'd0);
    rd(6'h27, d, e); check("R1 queue ptr 7", d, 64'd0);
    rd(6'h07, d, e); check("R1 tick", d, 64'd0);
    check("R1 ctx_word", ctx_word, 64'd0);
  endtask

  task automatic t_pstate;
    logic [63:0] d; logic e;
    wr(6'h00, 64'hFFFF_FFFF_FFFF_FFFF, e);
    rd(6'h00, d, e); check("R2 pstate all ones", d, 64'h13DE);
    wr(6'h00, 64'h0000_0000_0000_2C21, e);
    rd(6'h00, d, e); check("R2 pstate pattern", d, 64'h0000_0000_0000_2C21 & 64'h13DE);
  endtask

  task automatic t_tba;
    logic [63:0] d; logic e;
    wr(6'h01, 64'h1234_5678_9ABC_DEF0, e);
    rd(6'h01, d, e); check("R3 tba align", d, 64'h1234_5678_9ABC_8000);
  endtask

  task automatic t_levels;
    logic [63:0] d; logic e;
    wr(6'h02, 64'd99, e);
    rd(6'h02, d, e); check("R6 tl saturates", d, 64'(MAXTL));
    wr(6'h02, 64'd3, e);
    rd(6'h02, d, e); check("R6 tl plain", d, 64'd3);
    wr(6'h03, 64'hFF, e);
    rd(6'h03, d, e); check("R6 gl low bits", d, 64'd7);
  endtask

  task automatic t_cwp;
    logic [63:0] d; logic e;
    wr(6'h04, 64'(NWIN + 1), e);
    rd(6'h04, d, e); check("R7 cwp saturates", d, 64'(NWIN - 1));
    wr(6'h04, 64'(NWIN), e);
    rd(6'h04, d, e); check("R7 cwp at limit", d, 64'(NWIN - 1));
    wr(6'h04, 64'd3, e);
    rd(6'h04, d, e); check("R7 cwp plain", d, 64'd3);
  endtask

  task automatic t_stacks;
    logic [63:0] d; logic e;
    for (int l = 1; l <= MAXTL; l++) begin
      wr(6'h02, 64'(l), e);
      for (int k = 0; k < 5; k++) wr(6'(6'h10 + k), 64'(l * 256 + k), e);
    end
    for (int l = MAXTL; l >= 1; l--) begin
      wr(6'h02, 64'(l), e);
      for (int k = 0; k < 5; k++) begin
        rd(6'(6'h10 + k), d, e);
        check("R4 stack entry per level", d, 64'(l * 256 + k));
      end
    end
  endtask

  task automatic t_stack_tl0;
    logic [63:0] d; logic e;
    wr(6'h02, 64'd0, e);
    wr(6'h10, 64'hDEAD, e); check("R5 write at tl0 errs", 64'(e), 64'd1);
    rd(6'h14, d, e); check("R5 read at tl0 errs", 64'(e), 64'd1);
    check("R5 read at tl0 zero", d, 64'd0);
    wr(6'h02, 64'd1, e);
    rd(6'h10, d, e); check("R5 level1 untouched", d, 64'd256);
    wr(6'h02, 64'(MAXTL), e);
    rd(6'h10, d, e); check("R5 top level untouched", d, 64'(MAXTL * 256));
  endtask

  task automatic t_tlz;
    logic e;
    wr(6'h02, 64'd0, e);
    wr(6'h05, 64'h1, e); check("R8 irq set", 64'(tlz_irq), 64'd1);
    wr(6'h05, 64'h5, e); check("R8 irq masked by hpriv", 64'(tlz_irq), 64'd0);
    wr(6'h05, 64'h1, e);
    wr(6'h02, 64'd1, e); check("R8 irq off at tl1", 64'(tlz_irq), 64'd0);
    wr(6'h02, 64'd0, e); check("R8 irq back at tl0", 64'(tlz_irq), 64'd1);
    wr(6'h05, 64'h0, e); check("R8 irq off without tlz", 64'(tlz_irq), 64'd0);
  endtask

  task automatic t_ctx;
    logic [63:0] d, exp; logic e;
    wr(6'h05, 64'h24, e);
    wr(6'h00, 64'h0C, e);
    wr(6'h0B, 64'h8, e);
    wr(6'h0A, 64'h1A5, e);
    wr(6'h02, 64'd2, e);
    wr(6'h08, 64'hFFFF_1234, e);
    wr(6'h09, 64'h7_BEEF, e);
    exp = 64'hBEEF_1234_0002_A500 | 64'h2F;
    check("R9 ctx_word port", ctx_word, exp);
    rd(6'h0C, d, e); check("R9 ctx_word read", d, exp);
    wr(6'h0C, 64'h0, e); check("R12 write to ctx errs", 64'(e), 64'd1);
    check("R12 ctx unchanged", ctx_word, exp);
  endtask

  task automatic t_tick;
    logic [63:0] d, v, exp; logic e; logic [62:0] s;
    cycle_cnt = 63'd1000;
    v = 64'h8000_0000_0000_1237;
    wr(6'h07, v, e);
    cycle_cnt = 63'd1500;
    s = v[62:0] + 63'd500;
    exp = {1'b1, s[62:2], 2'b00};
    rd(6'h07, d, e); check("R10 tick advance with flag", d, exp);
    cycle_cnt = 63'd100;
    wr(6'h07, 64'd5, e);
    cycle_cnt = 63'd103;
    rd(6'h07, d, e); check("R10 tick offset wraps", d, 64'd8);
    cycle_cnt = 63'h7FFF_FFFF_FFFF_FFF0;
    wr(6'h07, 64'd4, e);
    cycle_cnt = 63'd20;
    rd(6'h07, d, e); check("R10 tick across counter wrap", d, 64'd40);
  endtask

  task automatic t_scr_q;
    logic [63:0] d; logic e;
    for (int i = 0; i < 8; i++) wr(6'(6'h18 + i), {32'hA5A5_0000 | 32'(i), 32'(i * 7)}, e);
    for (int i = 0; i < 8; i++) wr(6'(6'h20 + i), ~64'(i * 3), e);
    for (int i = 0; i < 8; i++) begin
      rd(6'(6'h18 + i), d, e); check("R11 scratch", d, {32'hA5A5_0000 | 32'(i), 32'(i * 7)});
    end
    for (int i = 0; i < 8; i++) begin
      rd(6'(6'h20 + i), d, e); check("R11 queue pointer", d, ~64'(i * 3));
    end
  endtask

  task automatic t_unmapped;
    logic [63:0] d; logic e;
    rd(6'h0D, d, e);
    check("R12 unmapped read errs", 64'(e), 64'd1);
    check("R12 unmapped read zero", d, 64'd0);
    @(negedge clk); check("R12 err one cycle", 64'(rsp_err), 64'd0);
    wr(6'h3F, 64'hFFFF, e); check("R12 unmapped write errs", 64'(e), 64'd1);
    rd(6'h06, d, e); check("R12 strand untouched", d, 64'h50000);
    check("R12 good read no err", 64'(e), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pstate();
    t_tba();
    t_levels();
    t_cwp();
    t_stacks();
    t_stack_tl0();
    t_tlz();
    t_ctx();
    t_tick();
    t_scr_q();
    t_unmapped();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule